// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches the inputs of a 24-pin GPIO port and raises a single active-high interrupt when a pin shows the event it has been programmed for. Each pin has three configuration bits. The first is a source enable. The second is an event mode, which selects edge or level detection. The third is a polarity bit, which selects rising edge or high level against falling edge or low level. Together these allow four trigger kinds per pin.

Software reaches the configuration bits through a byte-wide register interface. It shares that interface with the rest of the port. Detected events are latched into a read-only pending vector. Software clears pending bits by writing ones to an acknowledge register, in a write-one-to-clear handshake.

The pin inputs first pass through a two-flop synchronizer. Edges are then found by comparing each synchronized input with its value on the previous clock.

Top module: `gpio_irq_top`

## Requirements
- R1: After synchronous reset every configuration bit and every pending bit is 0, and `irq_o` is 0.
- R2: Pin n uses bit n mod 8 of byte n/8 in every register. Source enable sits at 0x48..0x4A, event mode at 0x4C..0x4E, polarity at 0x50..0x52, pending at 0x0C..0x0E and acknowledge at 0x54..0x56. Each configuration byte reads back the last value written to it.
- R3: With event mode 1 and polarity 1, a 0-to-1 change of an enabled pin sets its pending bit. A 1-to-0 change of that pin does not.
- R4: With event mode 1 and polarity 0, a 1-to-0 change of an enabled pin sets its pending bit. A 0-to-1 change does not.
- R5: With event mode 0 and polarity 1, an enabled pin held high sets its pending bit on every clock. After an acknowledge the bit is set again while the level persists.
- R6: With event mode 0 and polarity 0, an enabled pin held low sets its pending bit.
- R7: A pin whose source-enable bit is 0 never sets its pending bit. Clearing all enables masks every pin, and writing them again restores detection.
- R8: Writing 1 to an acknowledge bit clears the matching pending bit, and writing 0 leaves it unchanged. The acknowledge bytes read as 0. Writes to the pending bytes have no effect.
- R9: When an event and an acknowledge hit the same pin in the same cycle, the pending bit ends up set.
- R10: `irq_o` is a register that, one clock later, equals the OR of all pending bits.
- R11: Rewriting the event-mode or polarity bits of a static pin does not, by itself, produce an edge event. The previous-value sample is taken every clock, even while the pin is disabled.
- R12: A pending bit stays set until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The checker watches the following on every clock:
- each pending bit holds until an acknowledge reaches it;
- any detected event shows up in pending on the next clock, even against a simultaneous acknowledge;
- a disabled pin never gains a pending bit;
- the interrupt follows the OR of pending one clock later;
- the acknowledge bytes always read as zero.

Some behaviour only the bench scenarios can show:
- the choice among the four trigger kinds;
- that opposite edges are ignored;
- that a level re-arms after acknowledge;
- that a configuration rewrite creates no edge;
- that the edge sample keeps running while a pin is masked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PIN_COUNT = 24;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BANK_W    = 2;
    localparam int unsigned SYNC_LEN  = 2;

    // Window bases; each window holds one byte per group of eight pins
    localparam logic [7:0] PEND_BASE = 8'h0C;
    localparam logic [7:0] SRC_BASE  = 8'h48;
    localparam logic [7:0] MODE_BASE = 8'h4C;
    localparam logic [7:0] POL_BASE  = 8'h50;
    localparam logic [7:0] ACK_BASE  = 8'h54;

    typedef enum logic [2:0] {
        RK_NONE, RK_PEND, RK_SRC, RK_MODE, RK_POL, RK_ACK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BANK_W-1:0]  bank;
    } reg_sel_t;

    typedef struct packed {
        logic src;
        logic edge_mode;
        logic rise_high;
    } pin_cfg_t;

    function automatic logic in_win(input logic [7:0] a, input logic [7:0] base,
                                    input int unsigned nb);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + int'(nb));
    endfunction

    function automatic reg_sel_t decode_addr(input logic [7:0] a, input int unsigned nb);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.bank = '0;
        if (in_win(a, PEND_BASE, nb)) begin
            s.kind = RK_PEND; s.bank = BANK_W'(int'(a) - int'(PEND_BASE));
        end else if (in_win(a, SRC_BASE, nb)) begin
            s.kind = RK_SRC;  s.bank = BANK_W'(int'(a) - int'(SRC_BASE));
        end else if (in_win(a, MODE_BASE, nb)) begin
            s.kind = RK_MODE; s.bank = BANK_W'(int'(a) - int'(MODE_BASE));
        end else if (in_win(a, POL_BASE, nb)) begin
            s.kind = RK_POL;  s.bank = BANK_W'(int'(a) - int'(POL_BASE));
        end else if (in_win(a, ACK_BASE, nb)) begin
            s.kind = RK_ACK;  s.bank = BANK_W'(int'(a) - int'(ACK_BASE));
        end
        return s;
    endfunction

    // One pin's trigger decision from its settings and two successive samples
    function automatic logic trig_hit(input pin_cfg_t c, input logic now, input logic prev);
        logic hit;
        if (!c.src)
            hit = 1'b0;
        else if (c.edge_mode)
            hit = c.rise_high ? (now & ~prev) : (~now & prev);
        else
            hit = c.rise_high ? now : ~now;
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    input  logic [PINS-1:0] pend,
    output logic [PINS-1:0] src,
    output logic [PINS-1:0] mode,
    output logic [PINS-1:0] pol,
    output logic [PINS-1:0] ack,
    output logic [7:0]      rdata
);
    localparam int unsigned BANKS = PINS / BYTE_W;

    reg_sel_t        sel;
    logic [PINS-1:0] src_q, mode_q, pol_q;

    assign sel = decode_addr(addr, BANKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else if (we) begin
            for (int b = 0; b < int'(BANKS); b++) begin
                if (int'(sel.bank) == b) begin
                    case (sel.kind)
                        RK_SRC:  src_q[b*BYTE_W +: BYTE_W]  <= wdata;
                        RK_MODE: mode_q[b*BYTE_W +: BYTE_W] <= wdata;
                        RK_POL:  pol_q[b*BYTE_W +: BYTE_W]  <= wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Acknowledge is a one-cycle strobe, never stored
    always_comb begin
        ack = '0;
        if (we && sel.kind == RK_ACK)
            ack[int'(sel.bank)*BYTE_W +: BYTE_W] = wdata;
    end

    always_comb begin
        case (sel.kind)
            RK_PEND: rdata = pend[int'(sel.bank)*BYTE_W +: BYTE_W];
            RK_SRC:  rdata = src_q[int'(sel.bank)*BYTE_W +: BYTE_W];
            RK_MODE: rdata = mode_q[int'(sel.bank)*BYTE_W +: BYTE_W];
            RK_POL:  rdata = pol_q[int'(sel.bank)*BYTE_W +: BYTE_W];
            default: rdata = 8'h00;
        endcase
    end

    assign src  = src_q;
    assign mode = mode_q;
    assign pol  = pol_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_s,
    input  logic [PINS-1:0] src,
    input  logic [PINS-1:0] mode,
    input  logic [PINS-1:0] pol,
    input  logic [PINS-1:0] ack,
    output logic [PINS-1:0] hit,
    output logic [PINS-1:0] pend,
    output logic            irq
);
    logic [PINS-1:0] prev_q, pend_q;
    logic            irq_q;

    for (genvar i = 0; i < int'(PINS); i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg    = '{src: src[i], edge_mode: mode[i], rise_high: pol[i]};
        assign hit[i] = trig_hit(cfg, pin_s[i], prev_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= pin_s;
            pend_q <= (pend_q & ~ack) | hit;
            irq_q  <= |pend_q;
        end
    end

    assign pend = pend_q;
    assign irq  = irq_q;
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_i,
    input  logic            reg_we,
    input  logic [7:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            irq_o
);
    logic [PINS-1:0] pin_s, src_w, mode_w, pol_w, ack_w, hit_w, pend_w;

    gpio_irq_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    gpio_irq_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend_w), .src(src_w), .mode(mode_w), .pol(pol_w), .ack(ack_w),
        .rdata(reg_rdata)
    );

    gpio_irq_detect #(.PINS(PINS)) u_det (
        .clk(clk), .rst(rst), .pin_s(pin_s), .src(src_w), .mode(mode_w),
        .pol(pol_w), .ack(ack_w), .hit(hit_w), .pend(pend_w), .irq(irq_o)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      reg_addr,
    input logic [7:0]      reg_rdata,
    input logic            irq_o,
    input logic [PINS-1:0] pend,
    input logic [PINS-1:0] src,
    input logic [PINS-1:0] ack,
    input logic [PINS-1:0] hit
);
    localparam int unsigned BANKS = PINS / BYTE_W;

    // R12
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(pend) & ~$past(ack)) & ~pend)) == '0));

    // R9
    event_lands_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit) & ~pend) == '0));

    // R7
    masked_pin_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(src)) == '0));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq_o);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq_o);

    // R8
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (decode_addr(reg_addr, BANKS).kind == RK_ACK) |-> (reg_rdata == 8'h00));
endmodule

bind gpio_irq_top gpio_irq_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .pend(pend_w), .src(src_w), .ack(ack_w), .hit(hit_w)
);

// File: tb/gpio_irq_top_test.sv
module gpio_irq_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pin_i = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_top uut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares them after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq_o} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        while (sb_q.size() != 0) #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        @(negedge clk);
        sb_q.push_back('{is_irq: 1'b1, exp: {7'b0, e}, tag: tag});
        while (sb_q.size() != 0) #1;
    endtask

    task automatic set_pin(input int n, input logic v);
        @(negedge clk);
        pin_i[n] = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(4);

        // R1 reset state; R7 all-zero config (level-low, pin low) stays masked
        expect_rd(8'h0C, 8'h00, "R1 pending byte0 after reset");
        expect_rd(8'h0E, 8'h00, "R1 pending byte2 after reset");
        expect_rd(8'h48, 8'h00, "R1 source enable byte0 after reset");
        expect_rd(8'h51, 8'h00, "R1 polarity byte1 after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // R2 register map readback
        wr(8'h48, 8'hA5); wr(8'h49, 8'h3C); wr(8'h4A, 8'h0F);
        wr(8'h4C, 8'h11); wr(8'h4D, 8'h22); wr(8'h4E, 8'h33);
        wr(8'h50, 8'h44); wr(8'h51, 8'h55); wr(8'h52, 8'h66);
        expect_rd(8'h49, 8'h3C, "R2 source byte1 readback");
        expect_rd(8'h4E, 8'h33, "R2 mode byte2 readback");
        expect_rd(8'h50, 8'h44, "R2 polarity byte0 readback");
        for (int b = 0; b < 3; b++) begin
            wr(8'h48 + 8'(b), 8'h00);
            wr(8'h4C + 8'(b), 8'h00);
            wr(8'h50 + 8'(b), 8'h00);
        end
        for (int b = 0; b < 3; b++) wr(8'h54 + 8'(b), 8'hFF);
        settle(4);
        expect_rd(8'h0D, 8'h00, "R2 pending clear after config reset");

        // R3 rising edge on pin 3 (byte0 bit3)
        wr(8'h4C, 8'h08); wr(8'h50, 8'h08); wr(8'h48, 8'h08);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R11 enabling edge pin gives no event");
        set_pin(3, 1'b1);
        settle(4);
        expect_rd(8'h0C, 8'h08, "R3 rising edge sets pending");
        expect_irq(1'b1, "R10 irq follows pending");
        settle(10);
        expect_rd(8'h0C, 8'h08, "R12 pending stays set");
        set_pin(3, 1'b0);
        wr(8'h54, 8'h08);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R3 falling edge ignored, ack clears");
        expect_irq(1'b0, "R10 irq drops after ack");

        // R4 falling edge on pin 12 (byte1 bit4)
        set_pin(12, 1'b1);
        settle(4);
        wr(8'h4D, 8'h10); wr(8'h51, 8'h00); wr(8'h49, 8'h10);
        settle(3);
        expect_rd(8'h0D, 8'h00, "R4 no event while pin high");
        set_pin(12, 1'b0);
        settle(4);
        expect_rd(8'h0D, 8'h10, "R4 falling edge sets pending");
        wr(8'h55, 8'h00);
        settle(2);
        expect_rd(8'h0D, 8'h10, "R8 ack of zero has no effect");
        wr(8'h55, 8'h10);
        set_pin(12, 1'b1);
        settle(4);
        expect_rd(8'h0D, 8'h00, "R4 rising edge ignored after ack");

        // R5 level high on pin 17 (byte2 bit1)
        wr(8'h4E, 8'h00); wr(8'h52, 8'h02); wr(8'h4A, 8'h02);
        settle(3);
        expect_rd(8'h0E, 8'h00, "R5 no event while pin low");
        set_pin(17, 1'b1);
        settle(4);
        expect_rd(8'h0E, 8'h02, "R5 high level sets pending");
        wr(8'h56, 8'h02);
        settle(2);
        expect_rd(8'h0E, 8'h02, "R5 level re-asserts after ack");
        set_pin(17, 1'b0);
        settle(4);
        wr(8'h56, 8'h02);
        settle(2);
        expect_rd(8'h0E, 8'h00, "R5 clears once level gone");

        // R6 level low on pin 22 (byte2 bit6)
        set_pin(22, 1'b1);
        settle(4);
        wr(8'h4A, 8'h42);
        settle(3);
        expect_rd(8'h0E, 8'h00, "R6 no event while pin high");
        set_pin(22, 1'b0);
        settle(4);
        expect_rd(8'h0E, 8'h40, "R6 low level sets pending");
        set_pin(22, 1'b1);
        settle(4);
        wr(8'h56, 8'h40);
        settle(3);
        expect_rd(8'h0E, 8'h00, "R6 ack clears after level gone");
        expect_irq(1'b0, "R10 irq low with no pending");

        // R7 masking, R11 previous sample runs while disabled: pin 5 (byte0 bit5)
        wr(8'h4C, 8'h28); wr(8'h50, 8'h28);
        set_pin(5, 1'b1);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R7 disabled pin does not pend");
        wr(8'h48, 8'h28);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R11 edge seen while disabled is not replayed");
        wr(8'h48, 8'h00);
        set_pin(5, 1'b0);
        settle(3);
        set_pin(5, 1'b1);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R7 all enables cleared masks edges");
        wr(8'h48, 8'h28);
        set_pin(5, 1'b0);
        settle(3);
        set_pin(5, 1'b1);
        settle(4);
        expect_rd(8'h0C, 8'h20, "R7 restored enable detects edge");
        wr(8'h54, 8'h20);
        settle(2);

        // R11 rewriting polarity on a static edge pin
        wr(8'h50, 8'h20); wr(8'h50, 8'h28);
        settle(4);
        expect_rd(8'h0C, 8'h00, "R11 polarity rewrite creates no event");

        // R9 event and ack in the same cycle on pin 3
        set_pin(3, 1'b1);
        @(negedge clk);
        wr(8'h54, 8'h08);
        settle(2);
        expect_rd(8'h0C, 8'h08, "R9 event wins over simultaneous ack");
        wr(8'h54, 8'h08);
        settle(2);
        expect_rd(8'h0C, 8'h00, "R8 ack clears pending");

        // R8 pending is read-only, ack reads zero
        wr(8'h0C, 8'hFF);
        settle(2);
        expect_rd(8'h0C, 8'h00, "R8 write to pending ignored");
        expect_rd(8'h54, 8'h00, "R8 ack byte reads zero");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule